// File: doc/BRIEF.md
# USB Device Wakeup and Bus Reset Controller

This block is the global control section of a full-speed USB device. Firmware programs one control register and a 7-bit function address. The block watches the decoded bus line state (SE0 and J-idle) on the 48 MHz device clock. From that it detects a bus reset and the suspend state. When firmware asks for a remote wakeup and every condition allows it, the block drives the upstream K-state resume signal.

The block outputs the effective device address and the register read-back value. The read-back carries a read-only flag that shows a resume is pending or in progress. The block also outputs an enable for the transceiver and a clock enable for the core logic. The core clock enable models the gating of the 48 MHz clock. Packet handling, the transceiver itself and the decoding of standard requests are out of scope.

All durations are parameters given in clock cycles. They are bus reset length, idle-to-suspend time, minimum suspend time before a wakeup, and K-drive length. The defaults are 128 cycles, 3 ms, 5 ms and 2 ms at 48 MHz.

Top module: `usb_wake_ctl`

## Requirements
- R1: After hardware reset the control read-back is 0x00, the effective address is 0, and `xcvr_en`, `core_clk_en` and `drive_k` are low.
- R2: Control write bits are: bit0 enable, bit1 clock suspend, bit2 wake request, bit3 wake permit, bit4 configured, bit5 address enable. While enable is 0, every stored bit reads 0, `xcvr_en` and `core_clk_en` are low, and a write with bit0 = 0 clears the whole register.
- R3: While clock suspend is set, `core_clk_en` is low. SE0 of any length causes no bus reset, and no resume is started. Suspend detection keeps running.
- R4: SE0 held for `RST_CYC` (default 128) consecutive cycles with clocks running is a bus reset. It clears the configured and address-enable bits and gives one `bus_reset` pulse. SE0 of `RST_CYC-1` cycles has no effect.
- R5: `dev_addr` equals the programmed address while address enable is set, and is 0 while it is clear.
- R6: `suspended` rises after `SUSP_CYC` consecutive cycles of J-idle. Any non-idle cycle clears it and restarts the count.
- R7: A resume starts only if all of these hold: the wake request and wake permit are set, clocks are running, and the block has been suspended for `WAKE_MIN_CYC` cycles. The first K cycle follows the last qualifying cycle by one clock. A request made earlier stays pending.
- R8: `drive_k` stays high for exactly `RESUME_CYC` cycles. The cycle after it falls, the wake request bit reads 0 and `resume_done` is high for exactly one cycle.
- R9: Read-back bit7 is read-only. It is 1 from the first read after a write that sets both wake request and wake permit, until the resume ends or firmware writes the wake request to 0.
- R10: Read-back bit6 is reserved and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz device clock |
| rst_n | input | 1 | Active-low hardware reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | Control write data (bit map in R2) |
| addr_wr | input | 1 | Function address write strobe |
| addr_wdata | input | 7 | Function address write data |
| line_se0 | input | 1 | Decoded bus line is SE0 |
| line_j | input | 1 | Decoded bus line is J (idle) |
| ctrl_rdata | output | 8 | Control read-back: stored bits, bit6 zero, bit7 resume busy |
| dev_addr | output | 7 | Effective function address |
| xcvr_en | output | 1 | Transceiver enable |
| core_clk_en | output | 1 | Core 48 MHz clock enable |
| drive_k | output | 1 | Drive upstream resume K state |
| suspended | output | 1 | Bus is in suspend |
| bus_reset | output | 1 | One-cycle pulse after a detected bus reset |
| resume_done | output | 1 | One-cycle pulse after resume signalling ends |

## Verification
SE0 bursts have random lengths on both sides of the threshold, plus directed runs of 127 and 128 cycles. These separate an off-by-one in the reset counter from a correct one. A burst sent with the clock suspended shows whether detection is really gated. The idle tests place a wakeup request at 4 ms into suspend, then check the exact cycle of the first K and the K length. This separates a missing suspend-time gate from a miscounted one. Further tests make the request with clocks gated and cancel a pending request. They show that permission, clock state and pending state are each honoured. Random address and enable writes check the switch of the effective address to 0.

// File: rtl/usb_wake_pkg.sv
package usb_wake_pkg;
  localparam int ADDR_W = 7;
  localparam int WR_W   = 6;
  localparam int RD_W   = 8;

  // Writable control fields; en is bit 0 of the packed value.
  typedef struct packed {
    logic addr_en;
    logic cfg;
    logic wake_en;
    logic send_wake;
    logic clk_susp;
    logic en;
  } ctrl_t;

  function automatic logic [ADDR_W-1:0] eff_addr(input logic aen, input logic [ADDR_W-1:0] a);
    return aen ? a : '0;
  endfunction

  function automatic logic [RD_W-1:0] pack_rd(input ctrl_t c, input logic busy);
    return {busy, 1'b0, c};
  endfunction
endpackage

// File: rtl/usb_line_mon.sv
module usb_line_mon #(
  parameter int RST_CYC      = 128,
  parameter int SUSP_CYC     = 144000,
  parameter int WAKE_MIN_CYC = 240000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic core_on,
  input  logic se0,
  input  logic jst,
  input  logic hold,
  output logic bus_rst_evt,
  output logic suspended,
  output logic wake_ok
);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam int IW = $clog2(SUSP_CYC + 1);
  localparam int SW = $clog2(WAKE_MIN_CYC + 1);

  logic [RW-1:0] se0_cnt;
  logic [IW-1:0] idle_cnt;
  logic [SW-1:0] susp_cnt;
  logic          idle_ok;

  assign idle_ok     = jst & ~se0 & ~hold;
  assign bus_rst_evt = core_on & se0 & (se0_cnt == RW'(RST_CYC - 1));
  assign wake_ok     = suspended & (susp_cnt == SW'(WAKE_MIN_CYC));

  // Reset detection lives in the core domain: it only counts with clocks on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            se0_cnt <= '0;
    else if (!en)          se0_cnt <= '0;
    else if (core_on) begin
      if (!se0)                          se0_cnt <= '0;
      else if (se0_cnt != RW'(RST_CYC))  se0_cnt <= se0_cnt + 1'b1;
    end
  end

  // Suspend detection runs whenever the block is enabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      susp_cnt  <= '0;
      suspended <= 1'b0;
    end else if (!en || !idle_ok) begin
      idle_cnt  <= '0;
      susp_cnt  <= '0;
      suspended <= 1'b0;
    end else if (!suspended) begin
      if (idle_cnt == IW'(SUSP_CYC - 1)) begin
        suspended <= 1'b1;
        idle_cnt  <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end else if (susp_cnt != SW'(WAKE_MIN_CYC)) begin
      susp_cnt <= susp_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/usb_resume_gen.sv
module usb_resume_gen #(
  parameter int RESUME_CYC = 96000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic core_on,
  input  logic req,
  input  logic wake_ok,
  output logic drive_k,
  output logic resume_end,
  output logic done
);
  localparam int CW = $clog2(RESUME_CYC + 1);

  logic [CW-1:0] cnt;
  logic          start;

  assign start      = req & wake_ok & core_on & ~drive_k;
  assign resume_end = drive_k & core_on & (cnt == CW'(RESUME_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_k <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      done <= resume_end;
      if (!en) begin
        drive_k <= 1'b0;
        cnt     <= '0;
      end else if (start) begin
        drive_k <= 1'b1;
        cnt     <= '0;
      end else if (resume_end) begin
        drive_k <= 1'b0;
      end else if (drive_k && core_on) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_ctrl_reg.sv
module usb_ctrl_reg
  import usb_wake_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WR_W-1:0]   wdata,
  input  logic              awr,
  input  logic [ADDR_W-1:0] adata,
  input  logic              bus_rst_evt,
  input  logic              resume_end,
  input  logic              drive_k,
  output ctrl_t             ctrl,
  output logic              busy,
  output logic [ADDR_W-1:0] addr
);
  ctrl_t nxt;

  // Priority: write, then hardware clears, then the global enable.
  always_comb begin
    nxt = ctrl;
    if (wr) nxt = ctrl_t'(wdata);
    if (bus_rst_evt) begin
      nxt.cfg     = 1'b0;
      nxt.addr_en = 1'b0;
    end
    if (resume_end) nxt.send_wake = 1'b0;
    if (!nxt.en) nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      busy <= 1'b0;
      addr <= '0;
    end else begin
      ctrl <= nxt;
      busy <= nxt.en & ((nxt.send_wake & nxt.wake_en) | (drive_k & ~resume_end));
      if (awr) addr <= adata;
    end
  end
endmodule

// File: rtl/usb_wake_ctl.sv
module usb_wake_ctl
  import usb_wake_pkg::*;
#(
  parameter int RST_CYC      = 128,
  parameter int SUSP_CYC     = 144000,
  parameter int WAKE_MIN_CYC = 240000,
  parameter int RESUME_CYC   = 96000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [WR_W-1:0]   ctrl_wdata,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              line_se0,
  input  logic              line_j,
  output logic [RD_W-1:0]   ctrl_rdata,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              xcvr_en,
  output logic              core_clk_en,
  output logic              drive_k,
  output logic              suspended,
  output logic              bus_reset,
  output logic              resume_done
);
  ctrl_t             ctrl;
  logic              busy;
  logic [ADDR_W-1:0] addr_q;
  logic              core_on;
  logic              bus_rst_evt;
  logic              wake_ok;
  logic              resume_end;
  logic              wake_req;

  assign core_on  = ctrl.en & ~ctrl.clk_susp;
  assign wake_req = ctrl.send_wake & ctrl.wake_en;

  usb_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_wdata),
    .awr(addr_wr), .adata(addr_wdata), .bus_rst_evt(bus_rst_evt),
    .resume_end(resume_end), .drive_k(drive_k),
    .ctrl(ctrl), .busy(busy), .addr(addr_q)
  );

  usb_line_mon #(.RST_CYC(RST_CYC), .SUSP_CYC(SUSP_CYC), .WAKE_MIN_CYC(WAKE_MIN_CYC)) u_mon (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .core_on(core_on),
    .se0(line_se0), .jst(line_j), .hold(drive_k),
    .bus_rst_evt(bus_rst_evt), .suspended(suspended), .wake_ok(wake_ok)
  );

  usb_resume_gen #(.RESUME_CYC(RESUME_CYC)) u_res (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .core_on(core_on),
    .req(wake_req), .wake_ok(wake_ok),
    .drive_k(drive_k), .resume_end(resume_end), .done(resume_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_reset <= 1'b0;
    else        bus_reset <= bus_rst_evt;
  end

  assign ctrl_rdata  = pack_rd(ctrl, busy);
  assign dev_addr    = eff_addr(ctrl.addr_en, addr_q);
  assign xcvr_en     = ctrl.en;
  assign core_clk_en = core_on;
endmodule

// File: rtl/usb_wake_ctl_chk.sv
module usb_wake_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xcvr_en,
  input logic       core_clk_en,
  input logic       drive_k,
  input logic       resume_done,
  input logic       bus_rst_evt,
  input logic       wake_ok,
  input logic [7:0] ctrl_rdata,
  input logic [6:0] dev_addr
);
  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_en |-> !core_clk_en && ctrl_rdata == 8'h00);

  a_r2_off_no_k: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_en |=> !drive_k);

  a_r4_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_evt |=> ctrl_rdata[5:4] == 2'b00 && dev_addr == 7'd0);

  a_r5_addr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[5] |-> dev_addr == 7'd0);

  a_r7_start_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_k) |-> $past(wake_ok));

  a_r3_start_clocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_k) |-> $past(core_clk_en));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    resume_done |=> !resume_done);

  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    resume_done |-> !ctrl_rdata[2] && !drive_k);
endmodule

bind usb_wake_ctl usb_wake_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xcvr_en(xcvr_en), .core_clk_en(core_clk_en),
  .drive_k(drive_k), .resume_done(resume_done), .bus_rst_evt(bus_rst_evt),
  .wake_ok(wake_ok), .ctrl_rdata(ctrl_rdata), .dev_addr(dev_addr)
);

// File: tb/tb_usb_wake_ctl.sv
module tb_usb_wake_ctl;
  localparam int CLK_P = 10;
  localparam int RSTC  = 128;
  localparam int SUSP  = 300;
  localparam int WMIN  = 500;
  localparam int RES   = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [5:0] ctrl_wdata = '0;
  logic       addr_wr = 1'b0;
  logic [6:0] addr_wdata = '0;
  logic       line_se0 = 1'b0;
  logic       line_j = 1'b1;
  logic [7:0] ctrl_rdata;
  logic [6:0] dev_addr;
  logic       xcvr_en, core_clk_en, drive_k, suspended, bus_reset, resume_done;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  usb_wake_ctl #(.RST_CYC(RSTC), .SUSP_CYC(SUSP), .WAKE_MIN_CYC(WMIN), .RESUME_CYC(RES)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .addr_wr(addr_wr), .addr_wdata(addr_wdata), .line_se0(line_se0), .line_j(line_j),
    .ctrl_rdata(ctrl_rdata), .dev_addr(dev_addr), .xcvr_en(xcvr_en),
    .core_clk_en(core_clk_en), .drive_k(drive_k), .suspended(suspended),
    .bus_reset(bus_reset), .resume_done(resume_done)
  );

  // Expected read-back from the R2/R9/R10 bit map.
  function automatic logic [7:0] exp_rd(input logic [5:0] w, input logic busy);
    if (!w[0]) return 8'h00;
    return {busy, 1'b0, w};
  endfunction

  function automatic logic [6:0] exp_addr(input logic aen, input logic [6:0] a);
    return aen ? a : 7'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [5:0] d);
    ctrl_wr = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic wr_addr(input logic [6:0] a);
    addr_wr = 1'b1; addr_wdata = a;
    @(negedge clk);
    addr_wr = 1'b0;
  endtask

  task automatic glitch_k();
    line_se0 = 1'b0; line_j = 1'b0;
    @(negedge clk);
    line_j = 1'b1;
  endtask

  task automatic se0_burst(input int n, output int pulses);
    pulses = 0;
    line_se0 = 1'b1; line_j = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bus_reset) pulses++;
    end
    line_se0 = 1'b0; line_j = 1'b1;
    @(negedge clk);
    if (bus_reset) pulses++;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    int pulses, len, k, hi;
    logic [6:0] a;
    logic aen, cfg;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdata", ctrl_rdata, 8'h00);
    chk("R1 addr", dev_addr, 7'd0);
    chk("R1 outs", {xcvr_en, core_clk_en, drive_k}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: enable on
    wr_ctrl(6'h01);
    chk("R2 en", {xcvr_en, core_clk_en}, 2'b11);
    // R10: reserved bit with everything set (busy too, R9)
    wr_ctrl(6'h3F);
    chk("R10 rsvd", ctrl_rdata, exp_rd(6'h3F, 1'b1));
    wr_ctrl(6'h01);

    // R5: random address / enable patterns
    for (int i = 0; i < 16; i++) begin
      a = 7'($urandom); aen = 1'($urandom); cfg = 1'($urandom);
      wr_addr(a);
      wr_ctrl({aen, cfg, 4'b0001});
      chk("R5 addr", dev_addr, exp_addr(aen, a));
      chk("R5 rdata", ctrl_rdata, exp_rd({aen, cfg, 4'b0001}, 1'b0));
    end

    // R4: directed thresholds
    wr_addr(7'h55);
    wr_ctrl(6'h31);
    se0_burst(RSTC - 1, pulses);
    chk("R4 127 keep", ctrl_rdata, 8'h31);
    chk("R4 127 addr", dev_addr, 7'h55);
    chk("R4 127 pulse", pulses, 0);
    se0_burst(RSTC, pulses);
    chk("R4 128 clear", ctrl_rdata, 8'h01);
    chk("R4 128 addr", dev_addr, 7'd0);
    chk("R4 128 pulse", pulses, 1);
    // R4: random lengths either side
    for (int i = 0; i < 6; i++) begin
      len = ($urandom % 2) ? RSTC + int'($urandom % 64) : 40 + int'($urandom % 88);
      wr_ctrl(6'h31);
      se0_burst(len, pulses);
      chk("R4 rand rdata", ctrl_rdata, (len >= RSTC) ? 8'h01 : 8'h31);
      chk("R4 rand pulse", pulses, (len >= RSTC) ? 1 : 0);
    end

    // R3: clock suspended, long SE0 ignored
    wr_ctrl(6'h33);
    chk("R3 clk gated", core_clk_en, 1'b0);
    se0_burst(200, pulses);
    chk("R3 no reset", ctrl_rdata, 8'h33);
    chk("R3 no pulse", pulses, 0);

    // R6 / R7 / R8 / R9: suspend, early request, timed resume
    wr_ctrl(6'h01);
    glitch_k();
    for (int i = 0; i < SUSP - 1; i++) @(negedge clk);
    chk("R6 before", suspended, 1'b0);
    @(negedge clk);
    chk("R6 entered", suspended, 1'b1);
    for (int i = 0; i < 399; i++) @(negedge clk);
    wr_ctrl(6'h0D);          // request at 4 units of suspend
    k = SUSP + 400;
    chk("R9 busy set", ctrl_rdata, exp_rd(6'h0D, 1'b1));
    chk("R7 too early", drive_k, 1'b0);
    while (!drive_k && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk("R7 start cycle", k, SUSP + WMIN + 1);
    line_j = 1'b0;
    hi = 0;
    while (drive_k && hi < 5000) begin
      hi++;
      @(negedge clk);
    end
    chk("R8 length", hi, RES);
    chk("R8 done", resume_done, 1'b1);
    chk("R8 R9 cleared", ctrl_rdata, 8'h09);
    line_j = 1'b1;
    @(negedge clk);
    chk("R8 done once", resume_done, 1'b0);

    // R6: non-idle clears suspend
    for (int i = 0; i < SUSP + 5; i++) @(negedge clk);
    chk("R6 again", suspended, 1'b1);
    glitch_k();
    chk("R6 cleared", suspended, 1'b0);

    // R3: request with clocks gated waits; R3 suspend still detected
    wr_ctrl(6'h0F);
    hi = 0;
    for (int i = 0; i < SUSP + WMIN + 20; i++) begin
      @(negedge clk);
      if (drive_k) hi++;
    end
    chk("R3 susp works", suspended, 1'b1);
    chk("R3 no resume", hi, 0);
    wr_ctrl(6'h0D);
    chk("R7 one later", drive_k, 1'b0);
    @(negedge clk);
    chk("R7 started", drive_k, 1'b1);
    line_j = 1'b0;
    while (drive_k) @(negedge clk);
    line_j = 1'b1;
    @(negedge clk);

    // R9: cancel pending request
    glitch_k();
    wr_ctrl(6'h0D);
    chk("R9 pending", ctrl_rdata[7], 1'b1);
    wr_ctrl(6'h09);
    chk("R9 cancel", ctrl_rdata, 8'h09);
    hi = 0;
    for (int i = 0; i < SUSP + WMIN + 20; i++) begin
      @(negedge clk);
      if (drive_k) hi++;
    end
    chk("R9 no resume", hi, 0);

    // R2: disable clears everything
    wr_addr(7'h12);
    wr_ctrl(6'h31);
    wr_ctrl(6'h30);
    chk("R2 off rdata", ctrl_rdata, 8'h00);
    chk("R2 off outs", {xcvr_en, core_clk_en, dev_addr}, 9'd0);

    finish_run();
  end
endmodule